// File: doc/BRIEF.md
# Staged Bidirectional Barrel Shifter

This unit shifts a narrow value across a result word twice its width in a single clock. A 3-bit operation code selects one of three modes:

- left shift with zero fill,
- right shift with zero fill,
- right shift that fills with the value's top bit.

The distance input is an unsigned count. It may exceed the result width. The shift is built from a chain of selection stages, one stage for each distance bit, and stage i moves the word by 2^i places.

The double-width outcome is registered as separate high and low halves. A ready flag and an error flag are registered alongside it.

A left shift starts from the value placed in the low half, so bits that leave the low half enter the bottom of the high half. A right shift starts from the value placed in the high half, so bits fall down into the low half. An unsupported operation code drops ready and raises error. It also clears the low half and leaves the high half unchanged.

Top module: `shift_unit`

## Requirements
- R1: With op_i = 3'b001 and dist_i below 8, {res_hi_o, res_lo_o} becomes the 8-bit zero-extended val_i shifted left by dist_i, with vacated positions set to 0.
- R2: With op_i = 3'b001 and dist_i of 8 or more, both result halves become zero.
- R3: With op_i = 3'b001, a distance of 0 gives res_lo_o = val_i and res_hi_o = 0. A distance of 4 gives res_hi_o = val_i and res_lo_o = 0.
- R4: With op_i = 3'b010, {res_hi_o, res_lo_o} becomes {val_i, 4'b0000} shifted right by dist_i with zero fill. Distances of 8 or more give zero.
- R5: With op_i = 3'b011, {res_hi_o, res_lo_o} becomes {val_i, 4'b0000} shifted right by dist_i, with vacated upper bits filled with val_i[3]. Distances of 8 or more give eight copies of val_i[3].
- R6: For op_i of 001, 010 or 011, the next rising edge sets ready_o to 1 and err_o to 0. The result halves are loaded on that same edge.
- R7: For any other op_i value, the next rising edge sets ready_o to 0, sets err_o to 1 and clears res_lo_o. res_hi_o keeps its previous value.
- R8: While rst_ni is low, res_hi_o, res_lo_o, ready_o and err_o are 0, and they clear without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| val_i | input | 4 | Value to shift |
| dist_i | input | 4 | Unsigned shift distance, 0 to 15 |
| op_i | input | 3 | Operation code: 001 left, 010 logical right, 011 sign-filled right |
| res_hi_o | output | 4 | Upper half of the registered result |
| res_lo_o | output | 4 | Lower half of the registered result |
| ready_o | output | 1 | Registered: last operation code was supported |
| err_o | output | 1 | Registered: last operation code was unsupported |

## Verification
Every output comes out of a single register level. Result halves and flags are therefore due on the first rising edge after the inputs are applied. The bench drives inputs on the falling edge and compares on the following falling edge, half a period after the capturing edge. The reference model carries the previous high half forward, so the hold behaviour on unsupported codes is predicted rather than read back. The asynchronous clear is checked one nanosecond after reset falls, with no clock edge in between.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

  typedef enum logic [2:0] {
    OP_SHL = 3'b001,
    OP_SHR = 3'b010,
    OP_SAR = 3'b011
  } shift_op_e;

  typedef struct packed {
    logic valid;
    logic left;
    logic arith;
  } shift_ctl_t;

  function automatic shift_ctl_t decode_op(input logic [2:0] op);
    shift_ctl_t c;
    c = '0;
    unique case (op)
      OP_SHL:  begin c.valid = 1'b1; c.left = 1'b1; end
      OP_SHR:  c.valid = 1'b1;
      OP_SAR:  begin c.valid = 1'b1; c.arith = 1'b1; end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/shift_stage.sv
module shift_stage #(
  parameter int WORD_W = 8,
  parameter int AMT    = 1
) (
  input  logic [WORD_W-1:0] d_i,
  input  logic              en_i,
  input  logic              left_i,
  input  logic              fill_i,
  output logic [WORD_W-1:0] q_o
);

  logic [WORD_W-1:0] shl, shr;

  generate
    if (AMT >= WORD_W) begin : g_flood
      // every bit leaves the word
      assign shl = '0;
      assign shr = {WORD_W{fill_i}};
    end else begin : g_move
      assign shl = d_i << AMT;
      assign shr = {{AMT{fill_i}}, d_i[WORD_W-1:AMT]};
    end
  endgenerate

  always_comb begin
    if (!en_i)       q_o = d_i;
    else if (left_i) q_o = shl;
    else             q_o = shr;
  end

endmodule

// File: rtl/shift_core.sv
module shift_core #(
  parameter int DATA_W = 4,
  parameter int DIST_W = 4
) (
  input  logic [DATA_W-1:0]   val_i,
  input  logic [DIST_W-1:0]   dist_i,
  input  logic                left_i,
  input  logic                arith_i,
  output logic [2*DATA_W-1:0] word_o
);

  localparam int WORD_W = 2 * DATA_W;

  logic [WORD_W-1:0] chain [DIST_W+1];
  logic              fill;

  // left starts in low half, right starts in high half
  assign chain[0] = left_i ? {{DATA_W{1'b0}}, val_i} : {val_i, {DATA_W{1'b0}}};
  assign fill     = arith_i & ~left_i & val_i[DATA_W-1];

  for (genvar i = 0; i < DIST_W; i++) begin : g_stage
    shift_stage #(
      .WORD_W(WORD_W),
      .AMT   (1 << i)
    ) u_stage (
      .d_i   (chain[i]),
      .en_i  (dist_i[i]),
      .left_i(left_i),
      .fill_i(fill),
      .q_o   (chain[i+1])
    );
  end

  assign word_o = chain[DIST_W];

endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_unit_pkg::*;
#(
  parameter  int DATA_W = 4,
  localparam int DIST_W = $clog2(2 * DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] val_i,
  input  logic [DIST_W-1:0] dist_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] res_hi_o,
  output logic [DATA_W-1:0] res_lo_o,
  output logic              ready_o,
  output logic              err_o
);

  shift_ctl_t          ctl;
  logic [2*DATA_W-1:0] word;

  assign ctl = decode_op(op_i);

  shift_core #(
    .DATA_W(DATA_W),
    .DIST_W(DIST_W)
  ) u_core (
    .val_i  (val_i),
    .dist_i (dist_i),
    .left_i (ctl.left),
    .arith_i(ctl.arith),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_hi_o <= '0;
      res_lo_o <= '0;
      ready_o  <= 1'b0;
      err_o    <= 1'b0;
    end else if (ctl.valid) begin
      {res_hi_o, res_lo_o} <= word;
      ready_o              <= 1'b1;
      err_o                <= 1'b0;
    end else begin
      // high half held on unsupported code
      res_lo_o <= '0;
      ready_o  <= 1'b0;
      err_o    <= 1'b1;
    end
  end

endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter  int DATA_W = 4,
  localparam int DIST_W = $clog2(2 * DATA_W) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] val_i,
  input logic [DIST_W-1:0] dist_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] res_hi_o,
  input logic [DATA_W-1:0] res_lo_o,
  input logic              ready_o,
  input logic              err_o
);

  localparam int WORD_W = 2 * DATA_W;

  logic is_valid, is_shl, is_sar;
  assign is_shl   = (op_i == 3'b001);
  assign is_sar   = (op_i == 3'b011);
  assign is_valid = is_shl || (op_i == 3'b010) || is_sar;

  assert_shl_zero_dist_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_shl && dist_i == '0 |=> res_lo_o == $past(val_i) && res_hi_o == '0);

  assert_shl_half_dist_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_shl && dist_i == DIST_W'(DATA_W) |=> res_hi_o == $past(val_i) && res_lo_o == '0);

  assert_shl_far_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_shl && dist_i >= DIST_W'(WORD_W) |=> res_hi_o == '0 && res_lo_o == '0);

  assert_sar_far_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sar && dist_i >= DIST_W'(WORD_W) |=> {res_hi_o, res_lo_o} == {WORD_W{$past(val_i[DATA_W-1])}});

  assert_valid_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_valid |=> ready_o && !err_o);

  assert_bad_op_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_valid |=> !ready_o && err_o && res_lo_o == '0 && $stable(res_hi_o));

  assert_reset_clear_R8: assert property (@(posedge clk_i)
    !rst_ni |-> res_hi_o == '0 && res_lo_o == '0 && !ready_o && !err_o);

endmodule

bind shift_unit shift_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .val_i   (val_i),
  .dist_i  (dist_i),
  .op_i    (op_i),
  .res_hi_o(res_hi_o),
  .res_lo_o(res_lo_o),
  .ready_o (ready_o),
  .err_o   (err_o)
);

// File: tb/shift_unit_test.sv
`timescale 1ns/1ps
module shift_unit_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] val_i = '0;
  logic [3:0] dist_i = '0;
  logic [2:0] op_i = '0;
  logic [3:0] res_hi_o, res_lo_o;
  logic       ready_o, err_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0] exp_hi = '0, exp_lo = '0;
  logic       exp_rdy = 1'b0, exp_err = 1'b0;

  always #4 clk_i = ~clk_i;

  shift_unit uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .val_i   (val_i),
    .dist_i  (dist_i),
    .op_i    (op_i),
    .res_hi_o(res_hi_o),
    .res_lo_o(res_lo_o),
    .ready_o (ready_o),
    .err_o   (err_o)
  );

  function automatic logic [7:0] ref_word(input logic [2:0] op, input logic [3:0] a,
                                          input logic [3:0] d);
    logic signed [7:0] s;
    case (op)
      3'b001:  return {4'b0000, a} << d;
      3'b010:  return {a, 4'b0000} >> d;
      3'b011:  begin s = {a, 4'b0000}; return s >>> d; end
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op, input logic [3:0] d);
    case (op)
      3'b001:  return (d == 0 || d == 4) ? "R3" : (d >= 8) ? "R2" : "R1";
      3'b010:  return "R4";
      3'b011:  return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check_out(input string tag);
    n_chk++;
    if ({res_hi_o, res_lo_o} !== {exp_hi, exp_lo}) begin
      n_bad++;
      $display("FAIL %s result: got hi=%h lo=%h, expected hi=%h lo=%h",
               tag, res_hi_o, res_lo_o, exp_hi, exp_lo);
    end
    n_chk++;
    if ({ready_o, err_o} !== {exp_rdy, exp_err}) begin
      n_bad++;
      $display("FAIL %s flags: got ready=%b err=%b, expected ready=%b err=%b",
               (tag == "R7" || tag == "R8") ? tag : "R6", ready_o, err_o, exp_rdy, exp_err);
    end
  endtask

  // called on a falling edge; result compared one full period later
  task automatic apply(input logic [2:0] op, input logic [3:0] a, input logic [3:0] d);
    logic [7:0] w;
    op_i = op; val_i = a; dist_i = d;
    if (op == 3'b001 || op == 3'b010 || op == 3'b011) begin
      w = ref_word(op, a, d);
      {exp_hi, exp_lo} = w;
      exp_rdy = 1'b1; exp_err = 1'b0;
    end else begin
      exp_lo = '0; exp_rdy = 1'b0; exp_err = 1'b1;
    end
    @(negedge clk_i);
    check_out(tag_of(op, d));
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check_out("R8");
    rst_ni = 1'b1;

    // left, every distance
    for (int d = 0; d < 16; d++) apply(3'b001, 4'hB, 4'(d));
    apply(3'b001, 4'h7, 4'd0);
    apply(3'b001, 4'h7, 4'd4);
    apply(3'b001, 4'hF, 4'd8);
    // right modes
    for (int d = 0; d < 16; d++) apply(3'b010, 4'hD, 4'(d));
    for (int d = 0; d < 16; d++) apply(3'b011, 4'h9, 4'(d));
    apply(3'b011, 4'h5, 4'd9);
    apply(3'b011, 4'h5, 4'd2);
    // unsupported codes hold high half
    apply(3'b001, 4'hC, 4'd3);
    apply(3'b000, 4'h3, 4'd1);
    apply(3'b100, 4'h1, 4'd0);
    apply(3'b111, 4'hF, 4'd7);
    apply(3'b010, 4'hA, 4'd1);

    // asynchronous clear without a clock edge
    rst_ni = 1'b0;
    #1;
    exp_hi = '0; exp_lo = '0; exp_rdy = 1'b0; exp_err = 1'b0;
    check_out("R8");
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(3'b101, 4'h6, 4'd2);

    for (int k = 0; k < 400; k++)
      apply(3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule